// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block sits in a host bridge and decides, for every memory access below the top of the legacy one-megabyte area, whether the access is served by DRAM or forwarded to the PCI bus. Software programs the routing through a byte-wide configuration port. Seven attribute bytes hold a read enable and a write enable for each of thirteen shadow regions. A control byte governs the 128 KiB legacy video window, which system-management mode can see as RAM. The configuration port also returns the installed memory size, which a neighbouring controller supplies.

The BIOS region covers 0xF0000 to 0xFFFFF. Twelve 16 KiB expansion regions follow one another from 0xC0000 up to 0xEFFFF. Region i takes its two enables from the attribute byte at offset 0x59 + ceil(i/2). The window covers 0xA0000 to 0xBFFFF.

Lookups enter on a valid/ready stream and leave on a second valid/ready stream that carries the decision. The block holds one result. A lookup is accepted when `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the result slot is empty or is being drained in the same cycle, so a stalled consumer (`rsp_ready` low while `rsp_valid` is high) stops intake immediately and freezes the pending result.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset every attribute byte (offsets 0x59..0x5F) reads 0x00 and the window control byte (offset 0x72) reads 0x02, so every shadow region routes to PCI.
- R2: Writes to offsets 0x59..0x5F and 0x72 store the full byte, and the same offset reads it back combinationally. Every other offset reads 0x00 and ignores writes, including offset 0x57, which is read-only.
- R3: Offset 0x57 reads floor(`dram_mib`/8), saturated at 255.
- R4: Region 0 is 0xF0000..0xFFFFF. Region i (1..12) is 0xC0000 + (i-1)*0x4000 with a size of 0x4000. Region i uses byte 0x59 + ceil(i/2): odd regions use bits [1:0] of that byte and even regions use bits [5:4].
- R5: Within a region's field, the lower bit enables DRAM reads and the upper bit enables DRAM writes. An access whose direction is disabled gets `rsp_dram`=0 (PCI). Every shadow-region access has `rsp_hit`=1.
- R6: A non-SMM access (`lk_smm`=0) to 0xA0000..0xBFFFF has `rsp_hit`=1 and goes to DRAM exactly when bit 6 (open) of the control byte is set, for either direction.
- R7: An SMM access (`lk_smm`=1) to the window goes to DRAM exactly when bit 3 (global enable) of the control byte is set, for either direction.
- R8: An address outside the window and all thirteen regions, including any address at or above 0x100000, returns `rsp_hit`=0 and `rsp_dram`=0.
- R9: A lookup accepted on a clock edge produces `rsp_valid`=1 with its decision after that edge. `lk_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, the result stays valid and unchanged.
- R10: A configuration write is used by every lookup accepted on a later edge. A lookup accepted on the same edge as the write still sees the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset for write and read |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| dram_mib | input | MIB_W | Installed DRAM size in MiB |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with valid |
| lk_addr | input | ADDR_W | Lookup memory address |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_smm | input | 1 | Access issued in system-management mode |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_hit | output | 1 | Address falls in the window or a shadow region |
| rsp_dram | output | 1 | 1 = route to DRAM, 0 = route to PCI |

## Verification
The hardest case to reach from the ports is a configuration write and a lookup that land on the same edge, because the lookup must still see the old routing. The bench places both on one cycle, with the write flipping the window open bit, and checks the old decision before repeating the lookup. Stall behaviour needs a held result with a second request already waiting. The bench keeps `rsp_ready` low across two edges while a different request is offered, then releases it. For the routing itself, the bench sweeps every 4 KiB page edge from 0x98000 to 0x103FFF, in both directions and both modes, under the reset setting and four computed attribute/control patterns.

// File: rtl/smad_pkg.sv
package smad_pkg;
  localparam logic [7:0] MEMSZ_OFS    = 8'h57;
  localparam logic [7:0] ATTR_OFS     = 8'h59;
  localparam logic [7:0] WINCTL_OFS   = 8'h72;
  localparam logic [7:0] WINCTL_RST   = 8'h02;
  localparam int         WIN_OPEN_BIT = 6;
  localparam int         WIN_GEN_BIT  = 3;

  typedef struct packed {
    logic hit;
    logic dram;
  } smad_route_t;
endpackage

// File: rtl/smad_cfg_regs.sv
module smad_cfg_regs
  import smad_pkg::*;
#(
  parameter int NUM_EXP = 12,
  parameter int MIB_W   = 16,
  localparam int NREG   = NUM_EXP + 1,
  localparam int ATTR_N = NUM_EXP / 2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  input  logic [MIB_W-1:0] dram_mib,
  output logic [7:0]       rdata,
  output logic [NREG-1:0][1:0] reg_en,
  output logic             win_open,
  output logic             win_gen
);
  logic [ATTR_N-1:0][7:0] attr_q;
  logic [7:0]             ctl_q;
  logic [MIB_W-1:0]       units;
  logic [7:0]             memsz;

  for (genvar k = 0; k < ATTR_N; k++) begin : g_attr
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr_q[k] <= 8'h00;
      else if (we && addr == 8'(ATTR_OFS + k))
        attr_q[k] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= WINCTL_RST;
    else if (we && addr == WINCTL_OFS)
      ctl_q <= wdata;
  end

  assign units = dram_mib >> 3;
  assign memsz = (units > MIB_W'(255)) ? 8'hFF : units[7:0];

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < ATTR_N; k++)
      if (addr == 8'(ATTR_OFS + k)) rdata = attr_q[k];
    if (addr == WINCTL_OFS) rdata = ctl_q;
    if (addr == MEMSZ_OFS)  rdata = memsz;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_en
    localparam int B = (r + 1) / 2;
    if (r % 2 == 1) begin : g_lo
      assign reg_en[r] = attr_q[B][1:0];
    end else begin : g_hi
      assign reg_en[r] = attr_q[B][5:4];
    end
  end

  assign win_open = ctl_q[WIN_OPEN_BIT];
  assign win_gen  = ctl_q[WIN_GEN_BIT];
endmodule

// File: rtl/smad_region_map.sv
module smad_region_map
  import smad_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          NUM_EXP   = 12,
  parameter logic [31:0] BIOS_BASE = 32'h000F_0000,
  parameter int          BIOS_LOG2 = 16,
  parameter logic [31:0] EXP_BASE  = 32'h000C_0000,
  parameter int          EXP_LOG2  = 14,
  localparam int         NREG      = NUM_EXP + 1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_write,
  input  logic [NREG-1:0][1:0] reg_en,
  output smad_route_t          route
);
  logic [NREG-1:0] hit_v;
  logic [NREG-1:0] dram_v;

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    localparam int L = (r == 0) ? BIOS_LOG2 : EXP_LOG2;
    localparam logic [ADDR_W-1:0] BASE = (r == 0) ? ADDR_W'(BIOS_BASE)
                                   : ADDR_W'(EXP_BASE + 32'((r - 1) << EXP_LOG2));
    assign hit_v[r]  = (addr >> L) == (BASE >> L);
    assign dram_v[r] = hit_v[r] & (is_write ? reg_en[r][1] : reg_en[r][0]);
  end

  assign route.hit  = |hit_v;
  assign route.dram = |dram_v;
endmodule

// File: rtl/smad_smm_window.sv
module smad_smm_window
  import smad_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h000A_0000,
  parameter int          WIN_LOG2 = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  input  logic              win_open,
  input  logic              win_gen,
  output smad_route_t       route
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  assign route.hit  = (addr >> WIN_LOG2) == (BASE >> WIN_LOG2);
  assign route.dram = route.hit & (smm ? win_gen : win_open);
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import smad_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MIB_W   = 16,
  parameter int NUM_EXP = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [MIB_W-1:0]  dram_mib,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_write,
  input  logic              lk_smm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_dram
);
  localparam int NREG = NUM_EXP + 1;

  logic [NREG-1:0][1:0] reg_en;
  logic                 win_open;
  logic                 win_gen;
  smad_route_t          map_rt;
  smad_route_t          win_rt;
  smad_route_t          sel_rt;

  smad_cfg_regs #(.NUM_EXP(NUM_EXP), .MIB_W(MIB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .dram_mib(dram_mib), .rdata(cfg_rdata),
    .reg_en(reg_en), .win_open(win_open), .win_gen(win_gen)
  );

  smad_region_map #(.ADDR_W(ADDR_W), .NUM_EXP(NUM_EXP)) u_map (
    .addr(lk_addr), .is_write(lk_write), .reg_en(reg_en), .route(map_rt)
  );

  smad_smm_window #(.ADDR_W(ADDR_W)) u_win (
    .addr(lk_addr), .smm(lk_smm), .win_open(win_open),
    .win_gen(win_gen), .route(win_rt)
  );

  assign sel_rt   = win_rt.hit ? win_rt : map_rt;
  assign lk_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dram  <= 1'b0;
    end else if (lk_ready) begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit  <= sel_rt.hit;
        rsp_dram <= sel_rt.dram;
      end
    end
  end
endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk #(
  parameter int MIB_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_addr,
  input logic [7:0]       cfg_rdata,
  input logic [MIB_W-1:0] dram_mib,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_dram
);
  logic [MIB_W-1:0] units;
  assign units = dram_mib >> 3;

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_dram));

  a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !lk_ready);

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid);

  a_r8_miss_pci: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_dram);

  a_r3_memsz: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == 8'h57 |-> cfg_rdata == ((units > MIB_W'(255)) ? 8'hFF : units[7:0]));

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < 8'h57 || cfg_addr == 8'h58 || (cfg_addr > 8'h5F && cfg_addr != 8'h72))
      |-> cfg_rdata == 8'h00);
endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(.MIB_W(MIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .dram_mib(dram_mib), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_dram(rsp_dram)
);

// File: tb/tb_shadow_attr_decoder.sv
module tb_shadow_attr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] dram_mib = 16'd512;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = 32'h0;
  logic        lk_write = 1'b0;
  logic        lk_smm = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic        rsp_dram;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] m_attr [7];
  logic [7:0] m_ctl;

  always #5 clk = ~clk;

  shadow_attr_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dram_mib(dram_mib),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_write(lk_write), .lk_smm(lk_smm), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_dram(rsp_dram)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic expect_route(input logic [31:0] a, input logic w, input logic s,
                              output logic h, output logic d, output string tag);
    int idx;
    logic [7:0] b;
    logic [3:0] nib;
    h = 1'b0; d = 1'b0; idx = -1; tag = "R8 miss";
    if (a >= 32'hA0000 && a <= 32'hBFFFF) begin
      h = 1'b1;
      d = s ? m_ctl[3] : m_ctl[6];
      tag = s ? "R7 smm window" : "R6 open window";
    end else if (a >= 32'hF0000 && a <= 32'hFFFFF) begin
      idx = 0;
    end else if (a >= 32'hC0000 && a <= 32'hEFFFF) begin
      idx = 1 + int'((a - 32'hC0000) >> 14);
    end
    if (idx >= 0) begin
      h = 1'b1;
      b = m_attr[(idx + 1) / 2];
      nib = (idx % 2 == 1) ? b[3:0] : b[7:4];
      d = w ? nib[1] : nib[0];
      tag = "R4 R5 region";
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic w, input logic s);
    logic eh, ed;
    string tag;
    expect_route(a, w, s, eh, ed, tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_write = w; lk_smm = s;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R9 valid", 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(eh));
    check({tag, " dram"}, 32'(rsp_dram), 32'(ed));
  endtask

  task automatic sweep();
    for (logic [31:0] pg = 32'h98000; pg < 32'h104000; pg += 32'h1000)
      for (int o = 0; o < 2; o++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 2; s++)
            lookup(pg + (o == 1 ? 32'hFFF : 32'h0), w[0], s[0]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] held_a;
    for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
    m_ctl = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), 8'h00, "R1 attr reset");
    cfg_check(8'h72, 8'h02, "R1 ctl reset");
    check("R9 idle after reset", 32'(rsp_valid), 32'd0);
    sweep();
    lookup(32'h1000_0000, 1'b0, 1'b0); // R8 high address
    lookup(32'h0010_0000, 1'b1, 1'b1); // R8 just above

    // R3 memory size encoding
    dram_mib = 16'd512;   cfg_check(8'h57, 8'd64,  "R3 size 512");
    dram_mib = 16'd2039;  cfg_check(8'h57, 8'd254, "R3 size 2039");
    dram_mib = 16'd2047;  cfg_check(8'h57, 8'd255, "R3 size 2047");
    dram_mib = 16'd40000; cfg_check(8'h57, 8'd255, "R3 saturate");
    dram_mib = 16'd7;     cfg_check(8'h57, 8'd0,   "R3 below unit");

    // R2 ignored writes
    cfg_write(8'h57, 8'hAA); cfg_check(8'h57, 8'd0, "R2 size read-only");
    cfg_write(8'h58, 8'h5A); cfg_check(8'h58, 8'h00, "R2 below attr");
    cfg_write(8'h60, 8'hC3); cfg_check(8'h60, 8'h00, "R2 above attr");
    cfg_write(8'h71, 8'hFF); cfg_check(8'h71, 8'h00, "R2 near ctl");
    lookup(32'hF0000, 1'b0, 1'b0); // routing untouched by ignored writes

    // R2 R4 R5 R6 R7 patterns
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 7; k++) begin
        m_attr[k] = 8'((k * 37 + p * 91 + 13) ^ (p * 16 + k));
        cfg_write(8'(8'h59 + k), m_attr[k]);
      end
      m_ctl = 8'h02 | (p[1] ? 8'h40 : 8'h00) | (p[0] ? 8'h08 : 8'h00);
      cfg_write(8'h72, m_ctl);
      for (int k = 0; k < 7; k++) cfg_check(8'(8'h59 + k), m_attr[k], "R2 attr readback");
      cfg_check(8'h72, m_ctl, "R2 ctl readback");
      sweep();
    end

    // R10 write and lookup on the same edge
    m_ctl = 8'h02;
    cfg_write(8'h72, m_ctl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h42;
    lk_valid = 1'b1; lk_addr = 32'hA8000; lk_write = 1'b0; lk_smm = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    check("R10 same-edge old value", 32'(rsp_dram), 32'd0);
    m_ctl = 8'h42;
    lookup(32'hA8000, 1'b0, 1'b0); // R10 next lookup sees new value

    // R9 back-pressure
    held_a = 32'hB0000;
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_addr = held_a; lk_write = 1'b1; lk_smm = 1'b0;
    @(negedge clk);
    lk_addr = 32'h0000_4000; lk_write = 1'b0;
    #1;
    check("R9 stall ready low", 32'(lk_ready), 32'd0);
    check("R9 held valid", 32'(rsp_valid), 32'd1);
    check("R9 held dram", 32'(rsp_dram), 32'd1);
    @(negedge clk);
    check("R9 still held hit", 32'(rsp_hit), 32'd1);
    check("R9 still held dram", 32'(rsp_dram), 32'd1);
    rsp_ready = 1'b1;
    #1;
    check("R9 ready on drain", 32'(lk_ready), 32'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R9 second valid", 32'(rsp_valid), 32'd1);
    check("R9 second hit", 32'(rsp_hit), 32'd0);
    @(negedge clk);
    check("R9 empty after drain", 32'(rsp_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule